// File: doc/BRIEF.md
# Circular Execution Trace Recorder

This block records the retirement stream of one processor core into a circular on-chip memory. It forms a record in every cycle in which an instruction retires and tracing is on, and never holds up the pipeline. Each record holds five 32-bit words: status flags with a 30-bit time tag, the fetch address, the opcode, a value word, and the memory address of a load or store. The time tag is sampled from a time-base input shared with the system up-counter. Once the memory is full, new records overwrite the oldest ones.

A debug controller drives the control side. It turns tracing on and off, clears the write pointer and watches it, and holds capture off while it reads stored records one word at a time. A read returns the selected word one cycle after the request.

Top module: `exec_trace_buffer`

## Requirements
- R1: After reset, `wr_ptr` is 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: A record is written at `wr_ptr`, and `wr_ptr` rises by one at the next edge, exactly when `ret_valid`, `trace_en` and not `dbg_hold` and not `ptr_clr` all hold in that cycle. Records are taken on back-to-back cycles with no gap. With `trace_en` low, a retirement changes neither the pointer nor any stored record.
- R3: Word 0 of a record is {trap flag at bit 31, memory flag at bit 30, `time_tag` in bits 29:0}, all sampled in the retire cycle.
- R4: Word 1 is the fetch address with bits 1:0 forced to zero. Word 2 is the opcode.
- R5: Word 3 holds one of three values. On a trap it is the 8-bit trap type, zero-extended. Otherwise, for a memory instruction, it is the load/store data. Otherwise it is the result.
- R6: Word 4 is the load/store address for a memory instruction, and 0 for any other instruction.
- R7: Word selects 5, 6 and 7 read as 0.
- R8: `DEPTH` is a power of two. The pointer wraps from `DEPTH`-1 to 0, so the next record overwrites the oldest one and leaves the other entries as they were.
- R9: `ptr_clr` sets `wr_ptr` to 0 at the next edge. It wins over capture, and no record is written in a cycle where it is high.
- R10: While `dbg_hold` is high, retirements are not recorded: the pointer and the stored records stay unchanged.
- R11: Reads have one cycle of latency. `rd_en` in cycle n gives `rd_valid` high in cycle n+1, with the addressed word on `rd_data`. `rd_valid` is low in every other cycle, and `rd_data` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Tracing on |
| dbg_hold | input | 1 | Suspend capture during readout |
| ptr_clr | input | 1 | Clear the write pointer |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | 32 | Fetch address of the retiring instruction |
| ret_opcode | input | 32 | Opcode |
| ret_result | input | 32 | Result value |
| ret_is_mem | input | 1 | Instruction is a load or store |
| ret_mem_addr | input | 32 | Load/store address |
| ret_mem_data | input | 32 | Load/store data |
| ret_is_trap | input | 1 | Instruction trapped |
| ret_trap_type | input | 8 | Trap type |
| time_tag | input | 30 | Shared time-base value |
| rd_en | input | 1 | Read request |
| rd_entry | input | AW | Entry to read |
| rd_word | input | 3 | Word within the entry |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | Read word is valid |
| wr_ptr | output | AW | Next entry to write |

## Verification
On every cycle the assertions check how the pointer moves. It steps by exactly one on a capture and returns to zero on a clear. It stays put when tracing is off, when capture is held, or when nothing retires. They also check the read timing and that out-of-range word selects read as zero. The bench scenarios alone show the record layout: flag priority, the dropped address bits, and where the value word comes from. They also show that entries written before a wrap survive apart from the one overwritten, and that a clear, hold or disabled cycle leaves stored contents untouched.

// File: rtl/trace_buf_pkg.sv
package trace_buf_pkg;
  localparam int WORD_W    = 32;
  localparam int TAG_W     = 30;
  localparam int REC_WORDS = 5;
  localparam int SEL_W     = 3;

  typedef struct packed {
    logic [WORD_W-1:0] pc;
    logic [WORD_W-1:0] opcode;
    logic [WORD_W-1:0] result;
    logic [WORD_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_data;
    logic              is_mem;
    logic              is_trap;
    logic [7:0]        trap_type;
    logic [TAG_W-1:0]  tag;
  } retire_t;

  typedef logic [REC_WORDS-1:0][WORD_W-1:0] record_t;
endpackage

// File: rtl/trace_rec_pack.sv
module trace_rec_pack
  import trace_buf_pkg::*;
(
  input  retire_t ret,
  output record_t rec
);
  always_comb begin
    rec[0] = {ret.is_trap, ret.is_mem, ret.tag};
    rec[1] = {ret.pc[WORD_W-1:2], 2'b00};
    rec[2] = ret.opcode;
    if (ret.is_trap)
      rec[3] = {{(WORD_W-8){1'b0}}, ret.trap_type};
    else if (ret.is_mem)
      rec[3] = ret.mem_data;
    else
      rec[3] = ret.result;
    rec[4] = ret.is_mem ? ret.mem_addr : '0;
  end
endmodule

// File: rtl/trace_wptr.sv
module trace_wptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          clr,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_ce;

  always_comb begin
    ptr_ce = clr | cap;
    if (clr)
      ptr_d = '0;
    else
      ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (ptr_ce)
      ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !clr) |=> ptr == AW'($past(ptr) + 1'b1));
  // R9
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr == '0);
  // R10
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap && !clr) |=> $stable(ptr));
endmodule

// File: rtl/trace_store.sv
module trace_store
  import trace_buf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  record_t           wrec,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_entry,
  input  logic [SEL_W-1:0]  rd_word,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [REC_WORDS-1:0][WORD_W-1:0] bank_rd;
  logic [WORD_W-1:0] sel_word, rd_data_q, rd_data_d;
  logic              rd_valid_q;

  for (genvar w = 0; w < REC_WORDS; w++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we)
        mem[waddr] <= wrec[w];
    end
    assign bank_rd[w] = mem[rd_entry];
  end

  always_comb begin
    sel_word = '0;
    for (int k = 0; k < REC_WORDS; k++)
      if (rd_word == SEL_W'(k))
        sel_word = bank_rd[k];
    rd_data_d = rd_en ? sel_word : rd_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_en;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R11
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_data)));
  // R7
  rd_unused_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_word >= SEL_W'(REC_WORDS)) |=> rd_data == '0);
endmodule

// File: rtl/exec_trace_buffer.sv
module exec_trace_buffer
  import trace_buf_pkg::*;
#(
  parameter  int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trace_en,
  input  logic          dbg_hold,
  input  logic          ptr_clr,
  input  logic          ret_valid,
  input  logic [31:0]   ret_pc,
  input  logic [31:0]   ret_opcode,
  input  logic [31:0]   ret_result,
  input  logic          ret_is_mem,
  input  logic [31:0]   ret_mem_addr,
  input  logic [31:0]   ret_mem_data,
  input  logic          ret_is_trap,
  input  logic [7:0]    ret_trap_type,
  input  logic [29:0]   time_tag,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_entry,
  input  logic [2:0]    rd_word,
  output logic [31:0]   rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] wr_ptr
);
  retire_t ret_bus;
  record_t rec;
  logic    cap;

  always_comb begin
    ret_bus.pc        = ret_pc;
    ret_bus.opcode    = ret_opcode;
    ret_bus.result    = ret_result;
    ret_bus.mem_addr  = ret_mem_addr;
    ret_bus.mem_data  = ret_mem_data;
    ret_bus.is_mem    = ret_is_mem;
    ret_bus.is_trap   = ret_is_trap;
    ret_bus.trap_type = ret_trap_type;
    ret_bus.tag       = time_tag;
    cap = ret_valid & trace_en & ~dbg_hold & ~ptr_clr;
  end

  trace_rec_pack u_pack (
    .ret (ret_bus),
    .rec (rec)
  );

  trace_wptr #(.AW(AW)) u_wptr (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap),
    .clr   (ptr_clr),
    .ptr   (wr_ptr)
  );

  trace_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cap),
    .waddr    (wr_ptr),
    .wrec     (rec),
    .rd_en    (rd_en),
    .rd_entry (rd_entry),
    .rd_word  (rd_word),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  // R8
  depth_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (DEPTH & (DEPTH - 1)) == 0);
  // R2
  gated_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && (!trace_en || dbg_hold) && !ptr_clr) |=> $stable(wr_ptr));
endmodule

// File: tb/tb_exec_trace_buffer.sv
module tb_exec_trace_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);
  localparam int NVEC = 6;

  typedef struct packed {
    logic [31:0] pc, op, res, ma, md;
    logic        mem, trap;
    logic [7:0]  tt;
    logic [29:0] tag;
  } vec_t;

  // pc, opcode, result, mem addr, mem data, mem, trap, trap type, tag
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1000, 32'h8200_4001, 32'h0000_0042, 32'hDEAD_0000, 32'h1111_1111, 1'b0, 1'b0, 8'h00, 30'h0000_0001},
    '{32'h0000_1004, 32'hC200_6004, 32'h5555_AAAA, 32'h4000_0010, 32'hCAFE_F00D, 1'b1, 1'b0, 8'h00, 30'h0000_0002},
    '{32'h0000_1008, 32'hC220_6008, 32'h0, 32'h4000_0020, 32'h1234_5678, 1'b1, 1'b0, 8'h00, 30'h3FFF_FFFF},
    '{32'h0000_100F, 32'h91D0_2000, 32'h7777_7777, 32'h0, 32'h0, 1'b0, 1'b1, 8'h8B, 30'h2000_0000},
    '{32'h0000_2010, 32'hC400_0000, 32'h9999_9999, 32'h8000_0004, 32'hBBBB_BBBB, 1'b1, 1'b1, 8'h09, 30'h1555_5555},
    '{32'hFFFF_FFFE, 32'h0100_0000, 32'hFFFF_0000, 32'h0BAD_0BAD, 32'h0BAD_0BAD, 1'b0, 1'b0, 8'h00, 30'h0000_0000}
  };

  logic clk = 1'b0, rst_n;
  logic trace_en, dbg_hold, ptr_clr, ret_valid, ret_is_mem, ret_is_trap, rd_en;
  logic [31:0] ret_pc, ret_opcode, ret_result, ret_mem_addr, ret_mem_data, rd_data;
  logic [7:0] ret_trap_type;
  logic [29:0] time_tag;
  logic [AW-1:0] rd_entry, wr_ptr;
  logic [2:0] rd_word;
  logic rd_valid;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_trace_buffer #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .dbg_hold(dbg_hold),
    .ptr_clr(ptr_clr), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_opcode(ret_opcode), .ret_result(ret_result), .ret_is_mem(ret_is_mem),
    .ret_mem_addr(ret_mem_addr), .ret_mem_data(ret_mem_data),
    .ret_is_trap(ret_is_trap), .ret_trap_type(ret_trap_type),
    .time_tag(time_tag), .rd_en(rd_en), .rd_entry(rd_entry),
    .rd_word(rd_word), .rd_data(rd_data), .rd_valid(rd_valid), .wr_ptr(wr_ptr)
  );

  function automatic logic [31:0] exp_word(vec_t v, int w);
    case (w)
      0: return {v.trap, v.mem, v.tag};
      1: return {v.pc[31:2], 2'b00};
      2: return v.op;
      3: return v.trap ? {24'h0, v.tt} : (v.mem ? v.md : v.res);
      4: return v.mem ? v.ma : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(vec_t v, logic valid);
    ret_valid = valid; ret_pc = v.pc; ret_opcode = v.op; ret_result = v.res;
    ret_mem_addr = v.ma; ret_mem_data = v.md; ret_is_mem = v.mem;
    ret_is_trap = v.trap; ret_trap_type = v.tt; time_tag = v.tag;
  endtask

  task automatic read_word(int entry, int word, output logic [31:0] data);
    @(negedge clk);
    rd_en = 1'b1; rd_entry = AW'(entry); rd_word = 3'(word);
    @(negedge clk);
    rd_en = 1'b0;
    check("R11 rd_valid after request", 32'(rd_valid), 32'd1);
    data = rd_data;
  endtask

  function automatic vec_t mk(logic [31:0] pc);
    vec_t v = '{pc, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 8'h0, 30'h0};
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, held;
    rst_n = 1'b0; trace_en = 1'b0; dbg_hold = 1'b0; ptr_clr = 1'b0; rd_en = 1'b0;
    rd_entry = '0; rd_word = '0;
    drive(mk(32'h0), 1'b0);
    repeat (3) @(negedge clk);
    check("R1 wr_ptr reset", 32'(wr_ptr), 32'd0);
    check("R1 rd_valid reset", 32'(rd_valid), 32'd0);
    check("R1 rd_data reset", rd_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6: back-to-back captures from the vector table
    trace_en = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
    end
    ret_valid = 1'b0;
    check("R2 pointer after back-to-back captures", 32'(wr_ptr), NVEC);
    for (int i = 0; i < NVEC; i++)
      for (int w = 0; w < 5; w++) begin
        read_word(i, w, d);
        check($sformatf("R3-R6 entry %0d word %0d", i, w), d, exp_word(VECS[i], w));
      end

    // R7: unused word selects
    for (int w = 5; w < 8; w++) begin
      read_word(1, w, d);
      check("R7 unused word reads zero", d, 32'h0);
    end

    // R11: valid drops and data holds without a request
    read_word(0, 2, held);
    @(negedge clk);
    check("R11 rd_valid low when idle", 32'(rd_valid), 32'd0);
    check("R11 rd_data held", rd_data, held);

    // R9: clear, then clear together with a retirement
    ptr_clr = 1'b1;
    @(negedge clk);
    check("R9 clear to zero", 32'(wr_ptr), 32'd0);
    drive(mk(32'hAAAA_0000), 1'b1);
    @(negedge clk);
    ptr_clr = 1'b0; ret_valid = 1'b0;
    check("R9 clear wins over capture", 32'(wr_ptr), 32'd0);
    read_word(0, 1, d);
    check("R9 no record written on clear", d, exp_word(VECS[0], 1));

    // R10: hold suspends capture
    dbg_hold = 1'b1;
    drive(mk(32'hBBBB_0000), 1'b1);
    repeat (3) @(negedge clk);
    ret_valid = 1'b0;
    check("R10 pointer frozen under hold", 32'(wr_ptr), 32'd0);
    read_word(0, 1, d);
    check("R10 entry untouched under hold", d, exp_word(VECS[0], 1));
    dbg_hold = 1'b0;

    // R2: tracing off
    trace_en = 1'b0;
    drive(mk(32'hCCCC_0000), 1'b1);
    repeat (2) @(negedge clk);
    ret_valid = 1'b0;
    check("R2 pointer frozen when disabled", 32'(wr_ptr), 32'd0);
    read_word(0, 1, d);
    check("R2 entry untouched when disabled", d, exp_word(VECS[0], 1));

    // R8: fill the whole buffer, then overwrite the oldest
    trace_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      drive(mk(32'(i) << 2), 1'b1);
      @(negedge clk);
    end
    ret_valid = 1'b0;
    check("R8 pointer wraps to zero", 32'(wr_ptr), 32'd0);
    drive(mk(32'h0000_ABC0), 1'b1);
    @(negedge clk);
    ret_valid = 1'b0;
    check("R8 pointer after wrap capture", 32'(wr_ptr), 32'd1);
    read_word(0, 1, d);
    check("R8 oldest entry overwritten", d, 32'h0000_ABC0);
    read_word(1, 1, d);
    check("R8 next entry kept", d, 32'h4);
    read_word(DEPTH - 1, 1, d);
    check("R8 last entry kept", d, 32'(DEPTH - 1) << 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule